// File: doc/BRIEF.md
# Correlating Two-Bit Branch Predictor

This block guesses the direction of a conditional branch. A lookup presents the branch's program counter and receives a taken or not-taken answer in the same cycle. The answer comes from a 2-bit saturating counter. A set of low program-counter bits picks a row of counters. The global history of recent branch outcomes picks a column within that row. The block reports direction only and never computes a target address.

The live global history is visible at an output. The fetch side captures it at lookup time and carries it with the branch. When the branch resolves, the update port receives the branch address, that captured history and the real outcome. The block then trains the counter that made the guess and shifts the outcome into the live history.

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), so every lookup predicts not-taken, and `ghist` reads all zeros.
- R2: The counter used is the one at row `pc[ROW_BITS+1:2]` and column equal to the history value. The two lowest PC bits never affect which counter is read or trained.
- R3: `lk_taken` equals the upper bit of the selected counter (10 and 11 predict taken, 00 and 01 predict not-taken) and follows `lk_pc` and `ghist` in the same cycle.
- R4: An update with `up_taken`=1 raises the selected counter by one, saturating at 11.
- R5: An update with `up_taken`=0 lowers the selected counter by one, saturating at 00.
- R6: From a strong state, one opposite outcome keeps the prediction unchanged. A second consecutive opposite outcome flips it.
- R7: The counter trained is selected by `up_hist`, not by the live `ghist`.
- R8: On each update, `ghist` shifts left by one with `up_taken` entering bit 0 and the oldest bit dropped. Without an update, `ghist` holds.
- R9: When a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update.
- R10: When `up_valid` is low, the values on `up_pc`, `up_hist` and `up_taken` change no counter and leave `ghist` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| ghist | output | HIST_BITS | Live global history, to be captured with the branch |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_BITS | History captured when that branch was looked up |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The lookup port reads the counter in the column named by the live history, so a chosen counter can only be read when `ghist` happens to equal its column. Every update moves that history, and there is no direct way to set it. The stimulus handles this by steering. Before each probe, it issues updates to a scratch row whose outcomes spell the wanted column, oldest bit first, and only then looks up the branch of interest. This same steering is what allows a collision to be staged, with a lookup and an update on one counter in the same cycle, and what allows the bench to show that a stale history snapshot trains its own column rather than the live one.

// File: rtl/cbp_pkg.sv
`timescale 1ns/1ps
package cbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // saturating step of a two-bit direction counter
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'b01;
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'b01;
    return nxt;
  endfunction
endpackage

// File: rtl/cbp_index.sv
`timescale 1ns/1ps
module cbp_index #(
  parameter int PC_W      = 32,
  parameter int ROW_BITS  = 3,
  parameter int HIST_BITS = 3,
  localparam int IDX_W    = ROW_BITS + HIST_BITS
) (
  input  logic [PC_W-1:0]      pc,
  input  logic [HIST_BITS-1:0] hist,
  output logic [IDX_W-1:0]     idx
);
  // word-aligned instructions: the two low address bits carry no information
  logic unused_pc_bits;
  generate
    if (PC_W > ROW_BITS + 2) begin : g_upper
      assign unused_pc_bits = ^{pc[PC_W-1:ROW_BITS+2], pc[1:0]};
    end else begin : g_noupper
      assign unused_pc_bits = ^pc[1:0];
    end
  endgenerate

  // row from the address, column from the history
  assign idx = {pc[ROW_BITS+1:2], hist};
endmodule

// File: rtl/cbp_history.sv
`timescale 1ns/1ps
module cbp_history #(
  parameter int HIST_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [HIST_BITS-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_BITS-2:0], bit_in};
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist == {$past(hist[HIST_BITS-2:0]), $past(bit_in)}); // R8
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R10
endmodule

// File: rtl/cbp_table.sv
`timescale 1ns/1ps
module cbp_table
  import cbp_pkg::*;
#(
  parameter int ROW_BITS  = 3,
  parameter int HIST_BITS = 3,
  localparam int IDX_W    = ROW_BITS + HIST_BITS,
  localparam int ENTRIES  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  ctr_t mem [ENTRIES];

  // asynchronous read: the old value is seen by a lookup in an update cycle
  assign rd_taken = mem[rd_idx][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_WNT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_next(mem[wr_idx], wr_taken);
    end
  end

  // record of the last write, used only by the checks below
  logic             chk_wr;
  logic             chk_tak;
  logic [IDX_W-1:0] chk_idx;
  ctr_t             chk_old;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_wr  <= 1'b0;
      chk_tak <= 1'b0;
      chk_idx <= '0;
      chk_old <= CTR_WNT;
    end else begin
      chk_wr  <= wr_en;
      chk_tak <= wr_taken;
      chk_idx <= wr_idx;
      chk_old <= mem[wr_idx];
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (chk_wr && chk_tak && chk_old == CTR_ST) |-> mem[chk_idx] == CTR_ST); // R4
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (chk_wr && !chk_tak && chk_old == CTR_SNT) |-> mem[chk_idx] == CTR_SNT); // R5
  AST_STRONG_T_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (chk_wr && !chk_tak && chk_old == CTR_ST) |-> mem[chk_idx] == CTR_WT); // R6
  AST_STRONG_NT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (chk_wr && chk_tak && chk_old == CTR_SNT) |-> mem[chk_idx] == CTR_WNT); // R6
  AST_WEAK_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (chk_wr && chk_old == CTR_WNT && chk_tak) |-> mem[chk_idx][1]); // R6
endmodule

// File: rtl/corr_predictor.sv
`timescale 1ns/1ps
module corr_predictor #(
  parameter int PC_W      = 32,
  parameter int ROW_BITS  = 3,
  parameter int HIST_BITS = 3,
  localparam int IDX_W    = ROW_BITS + HIST_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PC_W-1:0]      lk_pc,
  output logic                 lk_taken,
  output logic [HIST_BITS-1:0] ghist,
  input  logic                 up_valid,
  input  logic [PC_W-1:0]      up_pc,
  input  logic [HIST_BITS-1:0] up_hist,
  input  logic                 up_taken
);
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;

  cbp_index #(.PC_W(PC_W), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) u_lk_index (
    .pc(lk_pc), .hist(ghist), .idx(lk_idx)
  );

  cbp_index #(.PC_W(PC_W), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) u_up_index (
    .pc(up_pc), .hist(up_hist), .idx(up_idx)
  );

  cbp_table #(.ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_taken(lk_taken),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_taken(up_taken)
  );

  cbp_history #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk(clk), .rst(rst), .shift_en(up_valid), .bit_in(up_taken), .hist(ghist)
  );

  AST_RESET_HIST: assert property (@(posedge clk)
    $past(rst) |-> ghist == '0); // R1
endmodule

// File: tb/corr_predictor_test.sv
`timescale 1ns/1ps
module corr_predictor_test;
  localparam int PC_W = 32;
  localparam int RB   = 3;
  localparam int HB   = 3;
  localparam int NENT = 1 << (RB + HB);
  localparam int HMSK = (1 << HB) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0;
  logic          lk_taken;
  logic [HB-1:0] ghist;
  logic          up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic [HB-1:0] up_hist = '0;
  logic          up_taken = 1'b0;

  corr_predictor #(.PC_W(PC_W), .ROW_BITS(RB), .HIST_BITS(HB)) uut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .ghist(ghist),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
  );

  always #4 clk = ~clk; // 125 MHz

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int mcnt [NENT];
  int mhist = 0;

  localparam logic [PC_W-1:0] PC_A   = 32'h0000_0104; // row 1
  localparam logic [PC_W-1:0] PC_SCR = 32'h0000_021c; // row 7, scratch

  function automatic int midx(input logic [PC_W-1:0] pc, input int h);
    return ((int'(pc >> 2) & ((1 << RB) - 1)) << HB) | (h & HMSK);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive, compare with the model, then advance the model
  task automatic cyc(input logic [PC_W-1:0] lpc, input logic uv, input logic [PC_W-1:0] upc,
                     input int uh, input logic ut, input int exp_pred, input string tag);
    int p;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_hist = HB'(uh); up_taken = ut;
    #1;
    p = (mcnt[midx(lpc, mhist)] >= 2) ? 1 : 0;
    check(lk_taken == p, "R3 model prediction", int'(lk_taken), p);
    check(int'(ghist) == mhist, "R8 model history", int'(ghist), mhist);
    if (exp_pred >= 0) check(int'(lk_taken) == exp_pred, tag, int'(lk_taken), exp_pred);
    @(posedge clk);
    if (uv) begin
      int k = midx(upc, uh);
      if (ut) mcnt[k] = (mcnt[k] == 3) ? 3 : mcnt[k] + 1;
      else    mcnt[k] = (mcnt[k] == 0) ? 0 : mcnt[k] - 1;
      mhist = ((mhist << 1) | int'(ut)) & HMSK;
    end
  endtask

  // bring the live history to h by training the scratch row
  task automatic steer(input int h);
    for (int b = HB - 1; b >= 0; b--) cyc(PC_SCR, 1'b1, PC_SCR, 0, h[b], -1, "");
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input int h, input logic t);
    cyc(PC_SCR, 1'b1, pc, h, t, -1, "");
  endtask

  task automatic probe(input logic [PC_W-1:0] pc, input int h, input int exp, input string tag);
    steer(h);
    cyc(pc, 1'b0, '0, 0, 1'b0, exp, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) mcnt[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(ghist == '0, "R1 history after reset", int'(ghist), 0);
    // R1: every row predicts not-taken
    for (int r = 0; r < (1 << RB); r++) cyc(PC_W'(r * 4), 1'b0, '0, 0, 1'b0, 0, "R1 reset counter");

    // R4: one taken from weak not-taken predicts taken
    train(PC_A, 5, 1'b1);
    probe(PC_A, 5, 1, "R4 step up");
    // R4 saturate, then R6 hysteresis
    train(PC_A, 5, 1'b1); train(PC_A, 5, 1'b1); train(PC_A, 5, 1'b1);
    train(PC_A, 5, 1'b0);
    probe(PC_A, 5, 1, "R6 one miss keeps taken");
    train(PC_A, 5, 1'b0);
    probe(PC_A, 5, 0, "R6 second miss flips");
    // R5 saturate at 00, using an unaligned address (R2)
    train(PC_A | 32'h3, 5, 1'b0); train(PC_A | 32'h3, 5, 1'b0); train(PC_A | 32'h3, 5, 1'b0);
    train(PC_A, 5, 1'b1);
    probe(PC_A | 32'h2, 5, 0, "R5 floor at 00 and R2 low bits ignored");

    // R9: same counter looked up and trained in one cycle
    steer(5);
    cyc(PC_A, 1'b1, PC_A, 5, 1'b1, 0, "R9 lookup sees pre-update value");
    probe(PC_A, 5, 1, "R9 update applied afterwards");

    // R7: snapshot column differs from live history
    steer(3);
    train(PC_A, 6, 1'b1);
    probe(PC_A, 3, 0, "R7 live column untouched");
    probe(PC_A, 6, 1, "R7 snapshot column trained");

    // R10: idle update port changes nothing
    steer(6);
    cyc(PC_A, 1'b0, PC_A, 6, 1'b0, 1, "R10 idle cycle");
    cyc(PC_A, 1'b0, PC_A, 6, 1'b0, 1, "R10 idle cycle");
    cyc(PC_A, 1'b0, PC_A, 6, 1'b0, 1, "R10 counter unchanged");
    check(int'(ghist) == 6, "R10 history unchanged", int'(ghist), 6);

    // mixed traffic against the model (R2 R3 R4 R5 R8)
    for (int n = 0; n < 400; n++) begin
      logic [PC_W-1:0] a = PC_W'($urandom & 32'h3f);
      logic [PC_W-1:0] b = PC_W'($urandom & 32'h3f);
      cyc(a, 1'($urandom), b, int'($urandom & HMSK), 1'($urandom), -1, "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule